// File: doc/BRIEF.md
# Strobe-Driven Four-Bit Adder Datapath

This block is a hand-operated arithmetic datapath. It has two operand registers, a ripple-carry adder and a small scratch memory of four words. Each word is four bits wide. The first register always supplies the adder's first operand and the second register always supplies the second. There is no operand selection and no decoder. The adder's sum is offered to every memory word at once. A one-hot write strobe per word picks which word captures it.

Reading also uses one strobe per word. Each word is ANDed with its own read enable, and the gated words are ORed onto one shared read bus. Both registers see that bus. Each register also takes a manually supplied value. A per-register select input picks the bus or the manual value, and a per-register write strobe commits the choice on a clock edge. An external controller, or a person at a panel, drives every strobe. The block keeps no program state of its own.

Top module: `strobe_adder_dp`

## Requirements
- R1: Synchronous active-low reset clears both registers and all four memory words to 0000 at the first clock edge with reset low.
- R2: `sum_o` equals the 4-bit sum of register A and register B at all times. Register A always feeds the first operand and register B the second.
- R3: The sum wraps modulo 16 and the carry out of bit 3 is discarded (1111 + 0001 = 0000, 1111 + 1111 = 1110).
- R4: Memory word k (bit k of `mem_wr`, k = 0..3) takes all four bits of `sum_o` at a clock edge where that bit is 1. Several set bits write the same sum to each selected word.
- R5: A memory word whose write bit is 0 keeps its contents, whatever the sum is doing.
- R6: `rd_bus_o` is the bitwise OR of every word whose `rd_en` bit is 1. It reads 0000 when `rd_en` is 0000.
- R7: With a register's write strobe high and its select low (0), the register loads its manual input at the clock edge.
- R8: With a register's write strobe high and its select high (1), the register loads `rd_bus_o` at the clock edge.
- R9: A register whose write strobe is low keeps its value.
- R10: The following sequence leaves word 1 at 1001 and word 3 at 0110:
  - load A=0011 and B=0001, then write word 0;
  - load A=0001, then write word 1;
  - load A=0010, then write word 2;
  - load A from word 0 and B from word 1, then write word 3;
  - load A from word 3 and B from word 2, then write word 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all storage |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_wr | input | 4 | Per-word write strobes, bit k for word k |
| rd_en | input | 4 | Per-word read enables, bit k for word k |
| a_wr | input | 1 | Register A write strobe |
| a_from_bus | input | 1 | Register A source: 1 read bus, 0 manual |
| a_manual | input | 4 | Manual value for register A |
| b_wr | input | 1 | Register B write strobe |
| b_from_bus | input | 1 | Register B source: 1 read bus, 0 manual |
| b_manual | input | 4 | Manual value for register B |
| reg_a_q | output | 4 | Register A contents |
| reg_b_q | output | 4 | Register B contents |
| sum_o | output | 4 | Adder sum, modulo 16 |
| rd_bus_o | output | 4 | Shared gated read bus |

## Verification
The assertions check the following on every cycle:
- the sum against the register contents, including wrap-around;
- register hold, manual load and bus load;
- the empty bus when no enable is set;
- capture and retention of a single enabled word while its enable stays steady.

Retention of words nobody is reading only shows up in the bench. It reads every word back after random traffic. The OR of several enabled words and the fixed worked sequence with its two final word values are also checked only by the bench.

// File: rtl/sad_pkg.sv
// Package: shared sizes and types for the strobe-driven adder datapath.
// Assumes a word of at least two bits so that the carry chain exists.
package sad_pkg;
    localparam int WORD_W = 4;
    localparam int NUM_WORDS = 4;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sad_ripple_adder.sv
// Ripple-carry adder. Bit 0 is a half adder and each higher bit is a full
// adder fed by the carry of the bit below. The carry out of the top bit is
// not formed, so the result wraps modulo 2**W. Assumes W >= 2.
module sad_ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    localparam int CW = W - 1;

    logic [CW-1:0] carry;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_half
            // Half adder on the lowest bit.
            assign sum[i] = op_a[i] ^ op_b[i];
            assign carry[i] = op_a[i] & op_b[i];
        end else begin : g_full
            // Full adder: sum bit, and a carry only below the top bit.
            assign sum[i] = op_a[i] ^ op_b[i] ^ carry[i-1];
            if (i < CW) begin : g_carry
                assign carry[i] = (op_a[i] & op_b[i]) | (carry[i-1] & (op_a[i] ^ op_b[i]));
            end
        end
    end
endmodule

// File: rtl/sad_word_store.sv
// Word store. Every word sees the same write data, and each word captures
// it only when its own strobe bit is set. Reads AND each word with its
// enable and OR the results onto one bus. Assumes a single clock domain.
module sad_word_store #(
    parameter int W = 4,
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wr_stb,
    input  logic [N-1:0] rd_stb,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_bus
);
    logic [W-1:0] words [N];

    for (genvar k = 0; k < N; k++) begin : g_word
        // One word: clear on reset, replace all bits when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[k] <= '0;
            end else if (wr_stb[k]) begin
                words[k] <= wr_data;
            end
        end
    end

    // Gated read bus: OR of every enabled word, zero when none is enabled.
    always_comb begin
        rd_bus = '0;
        for (int k = 0; k < N; k++) begin
            rd_bus = rd_bus | (words[k] & {W{rd_stb[k]}});
        end
    end
endmodule

// File: rtl/sad_operand_reg.sv
// Operand register. It loads either a manual value or the shared read bus
// on a clock edge where its strobe is high, and holds otherwise.
module sad_operand_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         from_bus,
    input  logic [W-1:0] manual,
    input  logic [W-1:0] bus,
    output logic [W-1:0] q
);
    // Capture the selected source while strobed, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= from_bus ? bus : manual;
        end
    end
endmodule

// File: rtl/strobe_adder_dp.sv
// Top level of the strobe-driven datapath. Operand routing is fixed:
// register A feeds adder input A and register B feeds adder input B. The
// sum is offered to every word of the store. The read bus feeds both
// registers. All strobes are assumed to come from outside, synchronous to clk.
module strobe_adder_dp #(
    parameter int W = sad_pkg::WORD_W,
    parameter int N = sad_pkg::NUM_WORDS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] mem_wr,
    input  logic [N-1:0] rd_en,
    input  logic         a_wr,
    input  logic         a_from_bus,
    input  logic [W-1:0] a_manual,
    input  logic         b_wr,
    input  logic         b_from_bus,
    input  logic [W-1:0] b_manual,
    output logic [W-1:0] reg_a_q,
    output logic [W-1:0] reg_b_q,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] rd_bus_o
);
    sad_operand_reg #(.W(W)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .wr(a_wr), .from_bus(a_from_bus),
        .manual(a_manual), .bus(rd_bus_o), .q(reg_a_q)
    );

    sad_operand_reg #(.W(W)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .wr(b_wr), .from_bus(b_from_bus),
        .manual(b_manual), .bus(rd_bus_o), .q(reg_b_q)
    );

    sad_ripple_adder #(.W(W)) u_adder (
        .op_a(reg_a_q), .op_b(reg_b_q), .sum(sum_o)
    );

    sad_word_store #(.W(W), .N(N)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_stb(mem_wr), .rd_stb(rd_en),
        .wr_data(sum_o), .rd_bus(rd_bus_o)
    );
endmodule

// File: rtl/sad_checker.sv
// Checker for strobe_adder_dp: relates the ports over time. It is bound to
// every instance of the top module below.
module sad_checker #(
    parameter int W = 4,
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] mem_wr,
    input logic [N-1:0] rd_en,
    input logic         a_wr,
    input logic         a_from_bus,
    input logic [W-1:0] a_manual,
    input logic         b_wr,
    input logic         b_from_bus,
    input logic [W-1:0] b_manual,
    input logic [W-1:0] reg_a_q,
    input logic [W-1:0] reg_b_q,
    input logic [W-1:0] sum_o,
    input logic [W-1:0] rd_bus_o
);
    // R1: a reset edge leaves both registers at zero.
    a_r1_reset_regs: assert property (@(posedge clk)
        !rst_n |=> (reg_a_q == '0 && reg_b_q == '0));

    // R2 and R3: the sum is the wrapped total of the registers.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == W'(reg_a_q + reg_b_q));

    // R4: a steadily read single word takes the sum when written.
    a_r4_word_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(rd_en) && (rd_en & mem_wr) != '0) |=>
        (rd_en != $past(rd_en) || rd_bus_o == $past(sum_o)));

    // R5: a steadily read single word that is not written keeps its value.
    a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(rd_en) && (rd_en & mem_wr) == '0) |=>
        (rd_en != $past(rd_en) || $stable(rd_bus_o)));

    // R6: no enable means an empty bus.
    a_r6_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en == '0) |-> (rd_bus_o == '0));

    // R7: manual load into either register.
    a_r7_manual_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && !a_from_bus) |=> reg_a_q == $past(a_manual));
    a_r7_manual_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && !b_from_bus) |=> reg_b_q == $past(b_manual));

    // R8: bus load into either register.
    a_r8_bus_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_from_bus) |=> reg_a_q == $past(rd_bus_o));
    a_r8_bus_b: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_from_bus) |=> reg_b_q == $past(rd_bus_o));

    // R9: a register without a strobe holds.
    a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_wr |=> $stable(reg_a_q));
    a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_wr |=> $stable(reg_b_q));
endmodule

bind strobe_adder_dp sad_checker #(.W(W), .N(N)) i_sad_checker (
    .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .rd_en(rd_en),
    .a_wr(a_wr), .a_from_bus(a_from_bus), .a_manual(a_manual),
    .b_wr(b_wr), .b_from_bus(b_from_bus), .b_manual(b_manual),
    .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .sum_o(sum_o), .rd_bus_o(rd_bus_o)
);

// File: tb/test_strobe_adder_dp.sv
`timescale 1ns/1ps
// Bench for strobe_adder_dp: directed corners, the worked sequence, and
// seeded random traffic, all compared against a bench-side model.
module test_strobe_adder_dp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mem_wr = '0, rd_en = '0;
    logic       a_wr = 1'b0, a_from_bus = 1'b0, b_wr = 1'b0, b_from_bus = 1'b0;
    logic [3:0] a_manual = '0, b_manual = '0;
    logic [3:0] reg_a_q, reg_b_q, sum_o, rd_bus_o;

    int compared = 0;
    int mismatched = 0;

    logic [3:0] m_a = '0, m_b = '0;
    logic [3:0] m_mem [4];

    strobe_adder_dp i_strobe_adder_dp (
        .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .rd_en(rd_en),
        .a_wr(a_wr), .a_from_bus(a_from_bus), .a_manual(a_manual),
        .b_wr(b_wr), .b_from_bus(b_from_bus), .b_manual(b_manual),
        .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .sum_o(sum_o), .rd_bus_o(rd_bus_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [3:0] exp_sum(input logic [3:0] x, input logic [3:0] y);
        logic [4:0] full;
        full = {1'b0, x} + {1'b0, y};
        return full[3:0];
    endfunction

    function automatic logic [3:0] exp_bus(input logic [3:0] en);
        logic [3:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) if (en[k]) r = r | m_mem[k];
        return r;
    endfunction

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational outputs,
    // let the rising edge act, then check the registers at the next fall.
    task automatic cyc(input logic [3:0] wr, input logic [3:0] rd,
                       input logic aw, input logic asel, input logic [3:0] am,
                       input logic bw, input logic bsel, input logic [3:0] bm);
        logic [3:0] s, bus;
        mem_wr = wr; rd_en = rd;
        a_wr = aw; a_from_bus = asel; a_manual = am;
        b_wr = bw; b_from_bus = bsel; b_manual = bm;
        #1;
        s = exp_sum(m_a, m_b);
        bus = exp_bus(rd);
        chk("R2 R3 sum", sum_o, s);
        chk("R6 read bus", rd_bus_o, bus);
        @(posedge clk);
        for (int k = 0; k < 4; k++) if (wr[k]) m_mem[k] = s;
        if (aw) m_a = asel ? bus : am;
        if (bw) m_b = bsel ? bus : bm;
        @(negedge clk);
        chk("R7 R8 R9 reg A", reg_a_q, m_a);
        chk("R7 R8 R9 reg B", reg_b_q, m_b);
    endtask

    // Read one set of words back with no writes and compare with a literal.
    task automatic peek(input logic [3:0] rd, input string req, input logic [3:0] exp);
        mem_wr = '0; rd_en = rd; a_wr = 1'b0; b_wr = 1'b0;
        #1;
        chk(req, rd_bus_o, exp);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) m_mem[k] = '0;
        // Dirty inputs during reset must not matter.
        mem_wr = 4'hF; a_wr = 1'b1; b_wr = 1'b1; a_manual = 4'h7; b_manual = 4'h9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mem_wr = '0; a_wr = 1'b0; b_wr = 1'b0;
        // R1: reset state.
        chk("R1 reg A after reset", reg_a_q, 4'h0);
        chk("R1 reg B after reset", reg_b_q, 4'h0);
        peek(4'hF, "R1 all words after reset", 4'h0);

        // R10: worked sequence.
        cyc(4'b0000, 4'b0000, 1, 0, 4'b0011, 1, 0, 4'b0001);
        cyc(4'b0001, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b0000, 1, 0, 4'b0001, 0, 0, 4'h0);
        cyc(4'b0010, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b0000, 1, 0, 4'b0010, 0, 0, 4'h0);
        cyc(4'b0100, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b0001, 1, 1, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b0010, 0, 0, 4'h0, 1, 1, 4'h0);
        cyc(4'b1000, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b1000, 1, 1, 4'h0, 0, 0, 4'h0);
        cyc(4'b0000, 4'b0100, 0, 0, 4'h0, 1, 1, 4'h0);
        cyc(4'b0010, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        peek(4'b0010, "R10 word 1", 4'b1001);
        peek(4'b1000, "R10 word 3", 4'b0110);
        peek(4'b0001, "R10 R5 word 0 kept", 4'b0100);
        peek(4'b0100, "R10 R5 word 2 kept", 4'b0011);
        // R6: several enables give the OR, none gives zero.
        peek(4'b1010, "R6 OR of words 1 and 3", 4'b1111);
        peek(4'b0101, "R6 OR of words 0 and 2", 4'b0111);
        peek(4'b0000, "R6 no enable", 4'b0000);

        // R3: wrap corners, then write both into words (R4 multi-strobe).
        cyc(4'b0000, 4'b0000, 1, 0, 4'hF, 1, 0, 4'h1);
        chk("R3 1111+0001", sum_o, 4'h0);
        cyc(4'b0011, 4'b0000, 1, 0, 4'hF, 1, 0, 4'hF);
        chk("R3 1111+1111", sum_o, 4'hE);
        cyc(4'b1100, 4'b0000, 0, 0, 4'h0, 0, 0, 4'h0);
        peek(4'b0001, "R4 multi write word 0", 4'h0);
        peek(4'b0010, "R4 multi write word 1", 4'h0);
        peek(4'b0100, "R4 multi write word 2", 4'hE);
        peek(4'b1000, "R4 multi write word 3", 4'hE);

        // Random traffic checked against the model, words read back after.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] wr;
            wr = ($urandom % 3 == 0) ? 4'(1 << ($urandom % 4)) : (($urandom % 8 == 0) ? 4'($urandom) : 4'h0);
            cyc(wr, 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom), 4'($urandom));
        end
        for (int k = 0; k < 4; k++) peek(4'(1 << k), "R4 R5 random word readback", m_mem[k]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule